// File: doc/BRIEF.md
# Two-Stage Column Word Loader

This block is the digital front end of a multichannel column driver. It spreads a stream of 12-bit sample words over a row of first-stage channel registers. When a start strobe is seen, it moves the whole row at once into a second row of output registers. Those output registers feed the converters downstream and keep their contents until the next transfer. This lets one line be shown while the next line is being collected.

Words can come from one bus or two. In single-bus mode, one word is taken on each rising clock edge and another on each falling edge. In dual-bus mode, two words are taken on every rising edge. Either way, a full row of `NCH` channels fills in `NCH/2` clock cycles. The fill order can run from the lowest channel up or from the highest channel down, so a mirrored image needs no reordering upstream.

Top module: `colword_loader`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every output word to zero and holds `xfer_pulse_o` low. It also leaves the loader idle, waiting for a start strobe.
- R2: When `xfer_i` is high at rising edge N, edge N+1 is the transfer edge. On that edge all output words take the first-stage contents, and `xfer_pulse_o` is high for exactly the one cycle after it. The same edge also captures the first words of a new fill.
- R3: In dual-bus mode (`dual_i` = 1 at the transfer edge), each rising edge of the fill writes `bus_a_i` to scan position 2k and `bus_b_i` to scan position 2k+1, for k = 0 to `NCH/2`-1.
- R4: In single-bus mode (`dual_i` = 0), each fill cycle takes one word on the rising edge and one on the falling edge. With `rev_i` = 0, `bus_a_i` on the rising edge goes to scan position 2k and `bus_b_i` on the falling edge to position 2k+1. With `rev_i` = 1, the two buses swap roles.
- R5: Scan position p maps to channel p when `rev_i` = 0 at the transfer edge, and to channel `NCH`-1-p when it is 1. Channel c is output bits [c*12+11 : c*12], with bit 11 as the MSB.
- R6: After `NCH` words have been loaded, further bus activity has no effect on the first stage until the next transfer edge.
- R7: Between transfer edges, the output words do not change.
- R8: In single-bus mode, the falling-edge word of the last fill cycle is included in a transfer whose transfer edge is the very next rising edge.
- R9: A transfer edge that arrives before the fill is complete restarts the fill at scan position 0. Channels not rewritten keep their earlier first-stage values.
- R10: The mode and direction are taken from `dual_i` and `rev_i` at the transfer edge. Changes on those pins during the rest of the fill are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used in single-bus mode |
| rst | input | 1 | Synchronous reset, active high |
| xfer_i | input | 1 | Start strobe, sampled on the rising edge |
| dual_i | input | 1 | 1 = two words per rising edge, 0 = one word per clock edge |
| rev_i | input | 1 | 1 = fill from the highest channel down |
| bus_a_i | input | 12 | First input word bus |
| bus_b_i | input | 12 | Second input word bus |
| out_words_o | output | NCH*12 | Output register words, channel c at bits c*12 upward |
| xfer_pulse_o | output | 1 | High for one cycle after each transfer edge |

## Verification
Two events can land on the same rising edge: the transfer of the first stage and the write of the falling-edge word captured just before it. The bench provokes this by raising the strobe together with the data of the last fill cycle, and by cutting fills short. In both cases the transfer edge must also commit a pending half-cycle word. The words that appear at the outputs after the transfer are compared with a row the bench built from the words it drove. That row includes the late word in its proper channel, and leaves stale values in channels that a shortened fill did not reach.

// File: rtl/colword_pkg.sv
`timescale 1ns/1ps
package colword_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_FILL = 1'b1
    } seq_state_e;

    // Map a position in fill order to a physical channel index.
    function automatic int unsigned scan_to_chan(input int unsigned pos,
                                                 input logic        rev,
                                                 input int unsigned nch);
        return rev ? (nch - 1 - pos) : pos;
    endfunction

endpackage

// File: rtl/colword_seq.sv
`timescale 1ns/1ps
module colword_seq
    import colword_pkg::*;
#(
    parameter int NCH = 12,
    localparam int CH_W = $clog2(NCH),
    localparam int NSLOT = NCH / 2,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            xfer_i,
    input  logic            dual_i,
    input  logic            rev_i,
    output logic            start_o,
    output logic            dir_o,
    output logic            wr0_en_o,
    output logic            wr0_from_b_o,
    output logic [CH_W-1:0] wr0_ch_o,
    output logic            wr1_en_o,
    output logic [CH_W-1:0] wr1_ch_o,
    output logic            half_en_o,
    output logic [CH_W-1:0] half_ch_o,
    output logic            pulse_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic              dual;
        logic              dir;
        logic              xfer_seen;
        logic              half_pend;
        logic [CH_W-1:0]   half_ch;
        logic              pulse;
    } seq_t;

    seq_t q, d;

    logic              act;
    logic [SLOT_W-1:0] cur_slot;
    logic              cur_dual;
    logic              cur_dir;
    int unsigned       pos0;
    logic [CH_W-1:0]   ch0;
    logic [CH_W-1:0]   ch1;

    always_comb begin
        d           = q;
        d.xfer_seen = xfer_i;
        d.pulse     = q.xfer_seen;
        d.half_pend = 1'b0;

        act      = q.xfer_seen || (q.state == SEQ_FILL);
        cur_slot = q.xfer_seen ? '0 : q.slot;
        cur_dual = q.xfer_seen ? dual_i : q.dual;
        cur_dir  = q.xfer_seen ? rev_i : q.dir;
        pos0     = 2 * int'(cur_slot);
        ch0      = CH_W'(scan_to_chan(pos0, cur_dir, NCH));
        ch1      = CH_W'(scan_to_chan(pos0 + 1, cur_dir, NCH));

        if (act) begin
            d.dual      = cur_dual;
            d.dir       = cur_dir;
            d.half_pend = !cur_dual;
            d.half_ch   = ch1;
            if (cur_slot == SLOT_W'(NSLOT - 1)) begin
                d.state = SEQ_IDLE;
                d.slot  = '0;
            end else begin
                d.state = SEQ_FILL;
                d.slot  = cur_slot + 1'b1;
            end
        end

        start_o      = q.xfer_seen;
        wr0_en_o     = act;
        wr0_ch_o     = ch0;
        wr0_from_b_o = !cur_dual && cur_dir;
        wr1_en_o     = act && cur_dual;
        wr1_ch_o     = ch1;
        half_en_o    = q.half_pend;
        half_ch_o    = q.half_ch;
        dir_o        = q.dir;
        pulse_o      = q.pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state     <= SEQ_IDLE;
            q.slot      <= '0;
            q.dual      <= 1'b0;
            q.dir       <= 1'b0;
            q.xfer_seen <= 1'b0;
            q.half_pend <= 1'b0;
            q.half_ch   <= '0;
            q.pulse     <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/colword_half.sv
`timescale 1ns/1ps
module colword_half #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_i,
    input  logic [W-1:0] bus_a_i,
    input  logic [W-1:0] bus_b_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = dir_i ? bus_a_i : bus_b_i;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/colword_bank.sv
`timescale 1ns/1ps
module colword_bank #(
    parameter int NCH = 12,
    parameter int W = 12,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             wr0_en_i,
    input  logic [CH_W-1:0]  wr0_ch_i,
    input  logic [W-1:0]     wr0_word_i,
    input  logic             wr1_en_i,
    input  logic [CH_W-1:0]  wr1_ch_i,
    input  logic [W-1:0]     wr1_word_i,
    input  logic             half_en_i,
    input  logic [CH_W-1:0]  half_ch_i,
    input  logic [W-1:0]     half_word_i,
    output logic [NCH*W-1:0] out_words_o
);

    typedef struct packed {
        logic [NCH-1:0][W-1:0] fill;
        logic [NCH-1:0][W-1:0] hold;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        // Late half-cycle word first, so a new capture on the same channel wins.
        if (half_en_i) d.fill[half_ch_i] = half_word_i;
        if (wr1_en_i)  d.fill[wr1_ch_i]  = wr1_word_i;
        if (wr0_en_i)  d.fill[wr0_ch_i]  = wr0_word_i;
        if (start_i) begin
            d.hold = q.fill;
            if (half_en_i) d.hold[half_ch_i] = half_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign out_words_o[c*W +: W] = q.hold[c];
    end

endmodule

// File: rtl/colword_loader.sv
`timescale 1ns/1ps
module colword_loader #(
    parameter int NCH = 12,
    parameter int W = 12,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_i,
    input  logic             dual_i,
    input  logic             rev_i,
    input  logic [W-1:0]     bus_a_i,
    input  logic [W-1:0]     bus_b_i,
    output logic [NCH*W-1:0] out_words_o,
    output logic             xfer_pulse_o
);

    logic            start;
    logic            dir_q;
    logic            wr0_en;
    logic            wr0_from_b;
    logic [CH_W-1:0] wr0_ch;
    logic            wr1_en;
    logic [CH_W-1:0] wr1_ch;
    logic            half_en;
    logic [CH_W-1:0] half_ch;
    logic [W-1:0]    half_word;
    logic [W-1:0]    wr0_word;

    colword_seq #(.NCH(NCH)) i_seq (
        .clk          (clk),
        .rst          (rst),
        .xfer_i       (xfer_i),
        .dual_i       (dual_i),
        .rev_i        (rev_i),
        .start_o      (start),
        .dir_o        (dir_q),
        .wr0_en_o     (wr0_en),
        .wr0_from_b_o (wr0_from_b),
        .wr0_ch_o     (wr0_ch),
        .wr1_en_o     (wr1_en),
        .wr1_ch_o     (wr1_ch),
        .half_en_o    (half_en),
        .half_ch_o    (half_ch),
        .pulse_o      (xfer_pulse_o)
    );

    colword_half #(.W(W)) i_half (
        .clk     (clk),
        .rst     (rst),
        .dir_i   (dir_q),
        .bus_a_i (bus_a_i),
        .bus_b_i (bus_b_i),
        .word_o  (half_word)
    );

    assign wr0_word = wr0_from_b ? bus_b_i : bus_a_i;

    colword_bank #(.NCH(NCH), .W(W)) i_bank (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .wr0_en_i    (wr0_en),
        .wr0_ch_i    (wr0_ch),
        .wr0_word_i  (wr0_word),
        .wr1_en_i    (wr1_en),
        .wr1_ch_i    (wr1_ch),
        .wr1_word_i  (bus_b_i),
        .half_en_i   (half_en),
        .half_ch_i   (half_ch),
        .half_word_i (half_word),
        .out_words_o (out_words_o)
    );

endmodule

// File: rtl/colword_loader_chk.sv
`timescale 1ns/1ps
module colword_loader_chk #(
    parameter int NCH = 12,
    parameter int W = 12,
    localparam int CH_W = $clog2(NCH)
) (
    input logic             clk,
    input logic             rst,
    input logic             xfer_i,
    input logic             xfer_pulse_o,
    input logic [NCH*W-1:0] out_words_o,
    input logic             wr0_en,
    input logic [CH_W-1:0]  wr0_ch,
    input logic             wr1_en,
    input logic [CH_W-1:0]  wr1_ch
);

    // R1: the cycle after reset shows cleared outputs and no pulse
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_words_o == '0) && !xfer_pulse_o);

    // R2: a strobe leads to a pulse two rising edges later
    a_r2_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
        xfer_i |-> ##2 xfer_pulse_o);

    // R2: a pulse only ever follows a strobe
    a_r2_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse_o |-> $past(xfer_i, 2));

    // R7: outputs move only together with the transfer pulse
    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !xfer_pulse_o |-> $stable(out_words_o));

    // R3: a dual-bus pair never targets one channel twice
    a_r3_pair_distinct: assert property (@(posedge clk) disable iff (rst)
        (wr0_en && wr1_en) |-> (wr0_ch != wr1_ch));

endmodule

bind colword_loader colword_loader_chk #(.NCH(NCH), .W(W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .xfer_i       (xfer_i),
    .xfer_pulse_o (xfer_pulse_o),
    .out_words_o  (out_words_o),
    .wr0_en       (wr0_en),
    .wr0_ch       (wr0_ch),
    .wr1_en       (wr1_en),
    .wr1_ch       (wr1_ch)
);

// File: tb/test_colword_loader.sv
`timescale 1ns/1ps
module test_colword_loader;

    localparam int NCH = 12;
    localparam int W = 12;
    localparam int NSLOT = NCH / 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             xfer_i = 1'b0;
    logic             dual_i = 1'b0;
    logic             rev_i = 1'b0;
    logic [W-1:0]     bus_a_i = '0;
    logic [W-1:0]     bus_b_i = '0;
    logic [NCH*W-1:0] out_words_o;
    logic             xfer_pulse_o;

    colword_loader #(.NCH(NCH), .W(W)) i_colword_loader (
        .clk          (clk),
        .rst          (rst),
        .xfer_i       (xfer_i),
        .dual_i       (dual_i),
        .rev_i        (rev_i),
        .bus_a_i      (bus_a_i),
        .bus_b_i      (bus_b_i),
        .out_words_o  (out_words_o),
        .xfer_pulse_o (xfer_pulse_o)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    logic [W-1:0] fill     [NCH];
    logic [W-1:0] exp_out  [NCH];
    logic [W-1:0] pend_snap[NCH];
    logic  exp_pulse = 1'b0;
    string prev_tag = "R1";

    function automatic int chan_of(input int pos, input logic rev);
        return rev ? (NCH - 1 - pos) : pos;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Check the outputs, then drive the next set of inputs, away from the rising edge.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic x, input logic d, input logic r, input string tag);
        @(negedge clk);
        #1;
        checks++;
        begin
            int bad = -1;
            for (int c = 0; c < NCH; c++)
                if (bad < 0 && out_words_o[c*W +: W] !== exp_out[c]) bad = c;
            if (bad >= 0) begin
                fails++;
                $display("FAIL %s: channel %0d actual %h expected %h", tag, bad,
                         out_words_o[bad*W +: W], exp_out[bad]);
            end
        end
        checks++;
        if (xfer_pulse_o !== exp_pulse) begin
            fails++;
            $display("FAIL %s: pulse actual %b expected %b", tag, xfer_pulse_o, exp_pulse);
        end
        bus_a_i = a;
        bus_b_i = b;
        xfer_i  = x;
        dual_i  = d;
        rev_i   = r;
    endtask

    // One fill of nslot cycles; slot 0 is driven just before a transfer edge.
    task automatic feed(input logic dual, input logic rev, input int nslot,
                        input logic xlast, input logic chk, input string xtag);
        for (int s = 0; s < nslot; s++) begin
            logic [W-1:0] w0, w1, a, b;
            w0 = W'($urandom);
            w1 = W'($urandom);
            if (dual || !rev) begin a = w0; b = w1; end
            else begin a = w1; b = w0; end
            if (s == 1 && chk) begin
                exp_out   = pend_snap;
                exp_pulse = 1'b1;
            end else begin
                exp_pulse = 1'b0;
            end
            step(a, b, xlast && (s == nslot - 1),
                 (s == 0) ? dual : 1'($urandom),
                 (s == 0) ? rev : 1'($urandom),
                 (s == 1 && chk) ? {"R2 ", xtag} : "R7");
            fill[chan_of(2 * s, rev)]     = w0;
            fill[chan_of(2 * s + 1, rev)] = w1;
        end
        pend_snap = fill;
        prev_tag  = dual ? "R3 R5 R10" : "R4 R5 R8 R10";
        if (nslot < NSLOT) prev_tag = {prev_tag, " R9"};
    endtask

    task automatic idle_then_xfer(input int n);
        exp_pulse = 1'b0;
        for (int i = 0; i < n; i++)
            step(W'($urandom), W'($urandom), 1'b0, 1'($urandom), 1'($urandom), "R6 R7");
        step(W'($urandom), W'($urandom), 1'b1, 1'b0, 1'b0, "R7");
        prev_tag = {prev_tag, " R6"};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int c = 0; c < NCH; c++) begin
            fill[c] = '0; exp_out[c] = '0; pend_snap[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then a first strobe
        step('0, '0, 1'b1, 1'b0, 1'b0, "R1");
        prev_tag = "R1";
        // Directed: each mode and direction, strobe raised with the last slot (R8)
        feed(1'b0, 1'b0, NSLOT, 1'b1, 1'b1, prev_tag);
        feed(1'b0, 1'b1, NSLOT, 1'b1, 1'b1, prev_tag);
        feed(1'b1, 1'b0, NSLOT, 1'b1, 1'b1, prev_tag);
        feed(1'b1, 1'b1, NSLOT, 1'b1, 1'b1, prev_tag);
        // R9: fill cut short, restarted in the opposite direction
        feed(1'b0, 1'b0, 3, 1'b1, 1'b1, prev_tag);
        feed(1'b0, 1'b1, 2, 1'b1, 1'b1, prev_tag);
        // R6 and R7: fill completes, junk follows, then a late strobe
        feed(1'b1, 1'b0, NSLOT, 1'b0, 1'b1, prev_tag);
        idle_then_xfer(4);
        feed(1'b0, 1'b1, NSLOT, 1'b0, 1'b1, prev_tag);
        idle_then_xfer(2);
        // Random mix
        for (int f = 0; f < 40; f++) begin
            int mode = $urandom_range(0, 3);
            if (mode == 0) begin
                feed(1'($urandom), 1'($urandom), NSLOT, 1'b0, 1'b1, prev_tag);
                idle_then_xfer($urandom_range(0, 5));
            end else if (mode == 1) begin
                feed(1'($urandom), 1'($urandom), $urandom_range(2, NSLOT - 1), 1'b1, 1'b1, prev_tag);
            end else begin
                feed(1'($urandom), 1'($urandom), NSLOT, 1'b1, 1'b1, prev_tag);
            end
        end
        // Final transfer check
        feed(1'b0, 1'b0, 2, 1'b0, 1'b1, prev_tag);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule